// File: doc/BRIEF.md
# Partial-Sum Tree Reduction Engine

This block adds up a long stream of unsigned integers in two phases. After a start pulse it takes `NUM_SLOTS * CHUNK_LEN` elements through a valid/ready input. Each run of `CHUNK_LEN` consecutive elements is summed into its own slot of a register bank. Slot 0 takes the first chunk, slot 1 the second, and so on.

Once the last element has been taken, the bank is folded in place. A live count starts at `NUM_SLOTS`. When the count is odd and above one, the top live slot is first added into slot 0 in a cycle of its own. Then the count is halved and every lower slot adds in its partner from the upper half, all in one cycle. Folding stops when one slot remains. A one-cycle done pulse then presents the total.

The slot count does not have to be a power of two. It may be anything from 2 to 128, and an odd count is handled by the extra fold-in cycle.

Top module: `psum_tree_reduce`

## Requirements
- R1: A start pulse taken while idle clears every slot. From the next cycle on, busy and inReady are both high.
- R2: During a run an element is taken only in a cycle where inValid and inReady are both high. Exactly NUM_SLOTS*CHUNK_LEN elements are taken per run. After the last one, inReady stays low until the next accepted start.
- R3: Each accumulator is DATA_W + clog2(NUM_SLOTS*CHUNK_LEN) bits wide. The result equals the exact unsigned sum even when every element is all ones.
- R4: The reduce phase keeps a count that starts at NUM_SLOTS. While the count is above one, each step works as follows:
  - If the count is odd, one cycle adds slot count-1 into slot 0.
  - Then one cycle halves the count (rounding down), and every slot i below the new count adds in slot i+count.
- R5: done is high for exactly one cycle, and result carries the total in that cycle. Let S be the number of reduce cycles from R4 (S = 2 for 3 slots, 4 for 10 slots, 8 for 100 slots and 1 for 2 slots). done is seen in the (S+1)-th cycle after the clock edge that took the last element.
- R6: A start pulse while busy is ignored. The run goes on and its total is unchanged.
- R7: busy is low after reset and in the cycle after done. It stays high from the cycle after an accepted start through the done cycle.
- R8: Data offered with inValid high while idle, or after the last element, is ignored and does not change the total.
- R9: The total is correct for slot counts that are not powers of two as well as for those that are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the block is idle |
| inValid | input | 1 | Input element present |
| inData | input | DATA_W | Unsigned input element |
| inReady | output | 1 | Block will take the element this cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse, result valid |
| result | output | DATA_W+clog2(NUM_SLOTS*CHUNK_LEN) | Final total |

## Verification
The assertions take as given that reset is applied before the first start, and that inValid and inData do not change during the cycle in which they are sampled. The bench changes every input only on the falling clock edge.

The bench holds inValid high with junk data before start and after the final element, so the R8 and R2 properties are exercised on real stimulus. It also raises start in the middle of a run, so the R6 property sees a busy start.

The bench uses only slot counts between 2 and 128, so the 8-bit count and index fields in the control strobes never overflow.

// File: rtl/psum_tree_pkg.sv
package psum_tree_pkg;

  // Width of slot index and live-count fields; covers slot counts up to 128.
  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACCUM,
    ST_REDUCE,
    ST_FINISH
  } psumState_t;

  // Strobes from the controller to the slot bank.
  typedef struct packed {
    logic             clearAll;
    logic             accumEn;
    logic [IDX_W-1:0] accumSlot;
    logic             foldEn;
    logic [IDX_W-1:0] foldSrc;
    logic             halveEn;
    logic [IDX_W-1:0] halfCnt;
  } psumCtrl_t;

endpackage

// File: rtl/psum_tree_ctrl.sv
module psum_tree_ctrl
  import psum_tree_pkg::*;
#(
  parameter int NUM_SLOTS = 10,
  parameter int CHUNK_LEN = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      inValid,
  output logic      inReady,
  output logic      busy,
  output logic      done,
  output psumCtrl_t ctrl
);

  localparam int ELEM_W = (CHUNK_LEN > 1) ? $clog2(CHUNK_LEN) : 1;

  psumState_t       state;
  logic [IDX_W-1:0] slotIdx;
  logic [ELEM_W-1:0] elemIdx;
  logic [IDX_W-1:0] liveCnt;
  logic             folded;
  logic             foldNow;
  logic             lastInChunk;
  logic             lastSlot;

  assign foldNow     = liveCnt[0] && !folded;
  assign lastInChunk = (elemIdx == ELEM_W'(CHUNK_LEN - 1));
  assign lastSlot    = (slotIdx == IDX_W'(NUM_SLOTS - 1));

  assign inReady = (state == ST_ACCUM);
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_FINISH);

  always_comb begin
    ctrl           = '0;
    ctrl.clearAll  = (state == ST_IDLE) && start;
    ctrl.accumEn   = (state == ST_ACCUM) && inValid;
    ctrl.accumSlot = slotIdx;
    ctrl.foldEn    = (state == ST_REDUCE) && foldNow;
    ctrl.foldSrc   = liveCnt - IDX_W'(1);
    ctrl.halveEn   = (state == ST_REDUCE) && !foldNow;
    ctrl.halfCnt   = liveCnt >> 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      slotIdx <= '0;
      elemIdx <= '0;
      liveCnt <= '0;
      folded  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_ACCUM;
            slotIdx <= '0;
            elemIdx <= '0;
          end
        end
        ST_ACCUM: begin
          if (inValid) begin
            if (lastInChunk) begin
              elemIdx <= '0;
              if (lastSlot) begin
                state   <= ST_REDUCE;
                liveCnt <= IDX_W'(NUM_SLOTS);
                folded  <= 1'b0;
              end else begin
                slotIdx <= slotIdx + IDX_W'(1);
              end
            end else begin
              elemIdx <= elemIdx + ELEM_W'(1);
            end
          end
        end
        ST_REDUCE: begin
          if (foldNow) begin
            folded <= 1'b1;
          end else begin
            liveCnt <= liveCnt >> 1;
            folded  <= 1'b0;
            if ((liveCnt >> 1) == IDX_W'(1)) state <= ST_FINISH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: the result strobe never lasts two cycles
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: elements are offered to the bank only inside a run
  assert_ready_in_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> busy);

  // R6: a start pulse during a run does not end it
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !done) |=> busy);

  // R4: the last halving step leads straight to the result
  assert_last_halve_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.halveEn && ctrl.halfCnt == IDX_W'(1)) |=> done);

endmodule

// File: rtl/psum_tree_bank.sv
module psum_tree_bank
  import psum_tree_pkg::*;
#(
  parameter int NUM_SLOTS = 10,
  parameter int DATA_W    = 16,
  parameter int ACC_W     = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  psumCtrl_t         ctrl,
  input  logic [DATA_W-1:0] inData,
  output logic [ACC_W-1:0]  sumOut
);

  logic [ACC_W-1:0] bank     [NUM_SLOTS];
  logic [ACC_W-1:0] bankNext [NUM_SLOTS];
  logic [ACC_W-1:0] partner  [NUM_SLOTS];
  logic [ACC_W-1:0] foldVal;
  logic [ACC_W-1:0] inWide;

  assign inWide = {{(ACC_W - DATA_W){1'b0}}, inData};
  assign sumOut = bank[0];

  // Value of the top live slot for the odd-count fold-in.
  always_comb begin
    foldVal = '0;
    for (int j = 0; j < NUM_SLOTS; j++)
      if (IDX_W'(j) == ctrl.foldSrc) foldVal = bank[j];
  end

  // Upper-half partner for each slot during a halving step.
  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      partner[i] = '0;
      for (int j = 0; j < NUM_SLOTS; j++)
        if (j == i + int'(ctrl.halfCnt)) partner[i] = bank[j];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      bankNext[i] = bank[i];
      if (ctrl.clearAll)
        bankNext[i] = '0;
      else if (ctrl.accumEn && ctrl.accumSlot == IDX_W'(i))
        bankNext[i] = bank[i] + inWide;
      else if (ctrl.foldEn && i == 0)
        bankNext[i] = bank[i] + foldVal;
      else if (ctrl.halveEn && i < int'(ctrl.halfCnt))
        bankNext[i] = bank[i] + partner[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) bank[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) bank[i] <= bankNext[i];
    end
  end

  // R1: a clear leaves the lowest and highest slot at zero
  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearAll |=> (bank[0] == '0 && bank[NUM_SLOTS-1] == '0));

  // R3: reduce additions into slot 0 never wrap
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.foldEn || ctrl.halveEn) |=> bank[0] >= $past(bank[0]));

  // R4: a fold-in cycle is always followed by a halving cycle
  assert_fold_then_halve_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.foldEn |=> ctrl.halveEn);

  // R2: accumulation and reduction never share a cycle
  assert_phase_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.accumEn |-> !(ctrl.foldEn || ctrl.halveEn));

endmodule

// File: rtl/psum_tree_reduce.sv
module psum_tree_reduce
  import psum_tree_pkg::*;
#(
  parameter int NUM_SLOTS = 10,
  parameter int CHUNK_LEN = 8,
  parameter int DATA_W    = 16,
  localparam int ACC_W    = DATA_W + $clog2(NUM_SLOTS * CHUNK_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              busy,
  output logic              done,
  output logic [ACC_W-1:0]  result
);

  psumCtrl_t ctrlBus;

  psum_tree_ctrl #(
    .NUM_SLOTS(NUM_SLOTS),
    .CHUNK_LEN(CHUNK_LEN)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .inValid (inValid),
    .inReady (inReady),
    .busy    (busy),
    .done    (done),
    .ctrl    (ctrlBus)
  );

  psum_tree_bank #(
    .NUM_SLOTS(NUM_SLOTS),
    .DATA_W   (DATA_W),
    .ACC_W    (ACC_W)
  ) bank_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrlBus),
    .inData (inData),
    .sumOut (result)
  );

  // R7: the result strobe only appears inside a run
  assert_done_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R6: the bank is cleared only from idle
  assert_clear_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrlBus.clearAll |-> !busy);

endmodule

// File: tb/psum_tree_reduce_tb_unit.sv
module psum_tree_reduce_tb_unit #(
  parameter int NUM_SLOTS = 3,
  parameter int CHUNK_LEN = 4,
  parameter int DATA_W    = 8
) (
  input  logic clk,
  input  logic rstN,
  output int   nChk,
  output int   nBad,
  output logic finished
);

  localparam int ACC_W = DATA_W + $clog2(NUM_SLOTS * CHUNK_LEN);
  localparam int TOTAL = NUM_SLOTS * CHUNK_LEN;

  logic              start;
  logic              inValid;
  logic [DATA_W-1:0] inData;
  logic              inReady;
  logic              busy;
  logic              done;
  logic [ACC_W-1:0]  result;

  psum_tree_reduce #(
    .NUM_SLOTS(NUM_SLOTS),
    .CHUNK_LEN(CHUNK_LEN),
    .DATA_W   (DATA_W)
  ) dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .inValid (inValid),
    .inData  (inData),
    .inReady (inReady),
    .busy    (busy),
    .done    (done),
    .result  (result)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s (slots=%0d): actual=%0d expected=%0d", req, NUM_SLOTS, act, exp);
    end
  endtask

  // Reduce cycles per R4, plus one for the done cycle (R5).
  function automatic int expLatency();
    int c = NUM_SLOTS;
    int s = 0;
    while (c > 1) begin
      if (c % 2 == 1) s++;
      c = c / 2;
      s++;
    end
    return s + 1;
  endfunction

  task automatic checkReset();
    @(negedge clk);
    check(busy == 1'b0, "R7 busy after reset", longint'(busy), 0);
    check(done == 1'b0, "R5 done after reset", longint'(done), 0);
    check(inReady == 1'b0, "R2 ready after reset", longint'(inReady), 0);
  endtask

  // mode 0: random, 1: all ones, 2: ascending pattern
  task automatic runSum(input int mode, input bit gaps, input bit midStart);
    longint unsigned expSum = 0;
    logic [DATA_W-1:0] d;
    int lat;
    // R8: junk offered while idle must be ignored
    inValid = 1'b1;
    inData  = '1;
    @(negedge clk);
    check(inReady == 1'b0, "R8 ready while idle", longint'(inReady), 0);
    @(negedge clk);
    inValid = 1'b0;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1 busy after start", longint'(busy), 1);
    check(inReady == 1'b1, "R1 ready after start", longint'(inReady), 1);
    for (int j = 0; j < TOTAL; j++) begin
      case (mode)
        0:       d = DATA_W'($urandom());
        1:       d = '1;
        default: d = DATA_W'(j * 7 + 3);
      endcase
      expSum += longint'(d);
      if (gaps && (j % 3 == 1)) begin
        inValid = 1'b0;
        @(negedge clk);
      end
      if (midStart && j == TOTAL / 2) start = 1'b1;   // R6
      inValid = 1'b1;
      inData  = d;
      while (!inReady) @(negedge clk);
      @(negedge clk);
      start = 1'b0;
    end
    // After the last element: keep offering junk (R8) and watch ready (R2)
    inValid = 1'b1;
    inData  = DATA_W'($urandom());
    lat = 1;
    while (!done && lat < 1000) begin
      check(inReady == 1'b0, "R2 ready low after last element", longint'(inReady), 0);
      @(negedge clk);
      lat++;
    end
    check(done == 1'b1, "R5 done seen", longint'(done), 1);
    check(lat == expLatency(), "R5 done latency", longint'(lat), longint'(expLatency()));
    check(longint'(result) == longint'(expSum), "R3 R9 total", longint'(result), longint'(expSum));
    check(busy == 1'b1, "R7 busy in done cycle", longint'(busy), 1);
    @(negedge clk);
    inValid = 1'b0;
    check(done == 1'b0, "R5 done single cycle", longint'(done), 0);
    check(busy == 1'b0, "R7 busy after done", longint'(busy), 0);
    check(inReady == 1'b0, "R2 ready after done", longint'(inReady), 0);
  endtask

  initial begin
    nChk = 0;
    nBad = 0;
    finished = 1'b0;
    start = 1'b0;
    inValid = 1'b0;
    inData = '0;
    wait (rstN === 1'b1);
    checkReset();
    runSum(0, 1'b0, 1'b0);   // random data
    runSum(1, 1'b0, 1'b0);   // all ones: R3 width
    runSum(0, 1'b1, 1'b1);   // gaps and start while busy: R6
    runSum(2, 1'b1, 1'b0);   // ascending pattern
    finished = 1'b1;
  end

endmodule

// File: tb/psum_tree_reduce_tb_top.sv
`timescale 1ns/1ps
module psum_tree_reduce_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int   chk [4];
  int   bad [4];
  logic fin [4];

  psum_tree_reduce_tb_unit #(.NUM_SLOTS(3),   .CHUNK_LEN(4), .DATA_W(8))
    u3   (.clk(clk), .rstN(rstN), .nChk(chk[0]), .nBad(bad[0]), .finished(fin[0]));
  psum_tree_reduce_tb_unit #(.NUM_SLOTS(10),  .CHUNK_LEN(3), .DATA_W(12))
    u10  (.clk(clk), .rstN(rstN), .nChk(chk[1]), .nBad(bad[1]), .finished(fin[1]));
  psum_tree_reduce_tb_unit #(.NUM_SLOTS(100), .CHUNK_LEN(2), .DATA_W(8))
    u100 (.clk(clk), .rstN(rstN), .nChk(chk[2]), .nBad(bad[2]), .finished(fin[2]));
  psum_tree_reduce_tb_unit #(.NUM_SLOTS(2),   .CHUNK_LEN(5), .DATA_W(16))
    u2   (.clk(clk), .rstN(rstN), .nChk(chk[3]), .nBad(bad[3]), .finished(fin[3]));

  initial begin
    int total;
    int failed;
    int cycles;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cycles = 0;
    while (!(fin[0] === 1'b1 && fin[1] === 1'b1 && fin[2] === 1'b1 && fin[3] === 1'b1)
           && cycles < 100000) begin
      @(negedge clk);
      cycles++;
    end
    total = 0;
    failed = 0;
    for (int k = 0; k < 4; k++) begin
      total += chk[k];
      failed += bad[k];
    end
    if (cycles >= 100000) begin
      total++;
      failed++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
    end
    $display("test done: total=%0d bad=%0d", total, failed);
    $finish;
  end

endmodule